// File: doc/BRIEF.md
# Region-State Speculation Hint Generator

This block sits on a processor's outgoing read-miss path. It keeps a small set-associative table of coarse, aligned memory regions and records for each one what the other processors may hold: clean copies, modifiable copies, or (as a history state) that one of those was true earlier. Each read miss is tagged with one extra bit. This hint bit tells the memory controller whether to start a DRAM read before the snoop response comes back. Reads to regions that other caches are likely to supply can then skip the speculative DRAM access and save its power.

Snoop responses feed an update port. A response that saw modifiable data marks the region dirty. A response that saw clean data marks it clean. A response where no other cache held the line demotes a recorded state to its history form. A 3-bit select picks one of six decision policies. These range from always speculating to never speculating, and include intermediate policies that hold back reads to known-dirty, likely-dirty or not-clean regions, or to all broadcast reads. The table lookup and the decision take one cycle. The tagged request leaves on registered outputs.

Top module: `region_hint_gen`

## Requirements
- R1: While `rst` is high, `out_valid` is 0, whatever the request inputs are. After reset, no region has a valid entry. Every region's state is unknown.
- R2: A request accepted in cycle t appears in cycle t+1 with `out_valid`=1, and with `out_addr` and `out_bcast` equal to the request's address and broadcast flag. A cycle without a request gives `out_valid`=0 in the next cycle.
- R3: With `policy_sel`=0, every read gets `out_spec`=1.
- R4: With `policy_sel`=1, every read gets `out_spec`=0.
- R5: With `policy_sel`=2, `out_spec`=0 only when the region is currently dirty. Unknown, clean and both history states give 1.
- R6: With `policy_sel`=3, `out_spec`=0 when the region is dirty or was dirty. Otherwise it is 1.
- R7: With `policy_sel`=4, `out_spec`=1 only when the region is clean or was clean. Unknown, dirty and was-dirty give 0.
- R8: With `policy_sel`=5, `out_spec` is the inverse of `req_bcast`, whatever the region state.
- R9: `policy_sel` values 6 and 7 behave like 0 (`out_spec`=1).
- R10: `upd_kind` encodes the update as follows:
  - 2 sets the region dirty.
  - 1 sets it clean.
  - 0 turns dirty into was-dirty and clean into was-clean. It leaves a history state unchanged and leaves an unknown region unknown.
  - 3 has no effect.
- R11: An update and a request to the same region in the same cycle: the request's hint uses the state after the update.
- R12: Each set holds `WAYS` regions with least-recently-used replacement. Both an update write and a request hit count as a use. An evicted region reads as unknown.
- R13: A region is `REGION_BYTES` bytes, aligned. All addresses inside one region share one state, and an adjacent region is independent. The region size must be a power of two, at least two lines and at most 4096 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A read miss is presented this cycle |
| req_addr | input | ADDR_W | Byte address of the read miss |
| req_bcast | input | 1 | The read will be broadcast as a snoop |
| policy_sel | input | 3 | Decision policy, 0 to 5 (6 and 7 act as 0) |
| upd_valid | input | 1 | A snoop-derived region update is presented |
| upd_addr | input | ADDR_W | Byte address whose region is updated |
| upd_kind | input | 2 | 0 no other holder, 1 clean held, 2 dirty held, 3 ignored |
| out_valid | output | 1 | Tagged request valid |
| out_addr | output | ADDR_W | Address of the tagged request |
| out_bcast | output | 1 | Broadcast flag of the tagged request |
| out_spec | output | 1 | Hint: 1 lets the controller read DRAM speculatively |

## Verification
The bench builds the block with four sets, two ways, a 20-bit address and 512-byte regions. With only four sets, three regions a multiple of four apart already fight over one set. That makes eviction and the least-recently-used order, including the touch from a request hit, reachable within a handful of updates. The small address space also lets a pseudo-random phase land on the same regions again and again, so every state meets every policy.

// File: rtl/rhg_pkg.sv
`timescale 1ns/1ps
package rhg_pkg;

  // external state of a tracked region (valid entries only)
  typedef enum logic [1:0] {
    RS_CLEAN     = 2'd0,
    RS_DIRTY     = 2'd1,
    RS_WAS_CLEAN = 2'd2,
    RS_WAS_DIRTY = 2'd3
  } rstate_e;

  // snoop-derived update kinds
  typedef enum logic [1:0] {
    UK_NONE  = 2'd0,
    UK_CLEAN = 2'd1,
    UK_DIRTY = 2'd2,
    UK_SKIP  = 2'd3
  } upd_kind_e;

  // decision policies
  localparam logic [2:0] POL_ALWAYS       = 3'd0;
  localparam logic [2:0] POL_NEVER        = 3'd1;
  localparam logic [2:0] POL_KNOWN_DIRTY  = 3'd2;
  localparam logic [2:0] POL_LIKELY_DIRTY = 3'd3;
  localparam logic [2:0] POL_NOT_CLEAN    = 3'd4;
  localparam logic [2:0] POL_ALL_SNOOPS   = 3'd5;

  // valid=0 means unknown state
  typedef struct packed {
    logic    valid;
    rstate_e st;
  } rview_t;

  // state after an update; valid=0 means "no write"
  function automatic rview_t next_view(logic hit, rstate_e old, upd_kind_e k);
    rview_t r;
    r.valid = 1'b0;
    r.st    = old;
    case (k)
      UK_DIRTY: begin r.valid = 1'b1; r.st = RS_DIRTY; end
      UK_CLEAN: begin r.valid = 1'b1; r.st = RS_CLEAN; end
      UK_NONE: begin
        r.valid = hit;
        if (old == RS_DIRTY)      r.st = RS_WAS_DIRTY;
        else if (old == RS_CLEAN) r.st = RS_WAS_CLEAN;
        else                      r.st = old;
      end
      default: r.valid = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rhg_lru.sv
`timescale 1ns/1ps
module rhg_lru #(
  parameter int SETS  = 256,
  parameter int WAYS  = 2,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             touch_en,
  input  logic [SET_W-1:0] touch_set,
  input  logic [WAY_W-1:0] touch_way,
  input  logic [SET_W-1:0] vic_set,
  output logic [WAY_W-1:0] vic_way
);

  // age 0 = most recent, WAYS-1 = oldest; ages in a set form a permutation
  logic [WAY_W-1:0] age_q [SETS][WAYS];
  logic [WAYS-1:0]  oldest_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= WAY_W'(w);
    end else if (touch_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way)
          age_q[touch_set][w] <= '0;
        else if (age_q[touch_set][w] < age_q[touch_set][touch_way])
          age_q[touch_set][w] <= age_q[touch_set][w] + 1'b1;
      end
    end
  end

  always_comb begin
    vic_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      oldest_v[w] = (age_q[vic_set][w] == WAY_W'(WAYS - 1));
      if (oldest_v[w]) vic_way = WAY_W'(w);
    end
  end

  // R12
  lru_single_oldest_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(oldest_v) == 1);

endmodule

// File: rtl/rhg_table.sv
`timescale 1ns/1ps
module rhg_table
  import rhg_pkg::*;
#(
  parameter int SETS  = 256,
  parameter int WAYS  = 2,
  parameter int TAG_W = 14,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_en,
  input  logic [SET_W-1:0] lk_set,
  input  logic [TAG_W-1:0] lk_tag,
  output rview_t           lk_view,
  input  logic             up_en,
  input  logic [SET_W-1:0] up_set,
  input  logic [TAG_W-1:0] up_tag,
  input  upd_kind_e        up_kind
);

  logic [WAYS-1:0] lk_hit_v, up_hit_v, up_vld_v, wr_en;
  rstate_e         lk_st_v [WAYS];
  rstate_e         up_st_v [WAYS];

  // one tag/state memory per way, written synchronously, read asynchronously
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [TAG_W-1:0] tag_q [SETS];
    rstate_e          st_q  [SETS];
    logic [SETS-1:0]  vld_q;

    always_ff @(posedge clk) begin
      if (wr_en[w]) begin
        tag_q[up_set] <= up_tag;
        st_q[up_set]  <= wr_view.st;
      end
    end

    always_ff @(posedge clk) begin
      if (rst)           vld_q         <= '0;
      else if (wr_en[w]) vld_q[up_set] <= 1'b1;
    end

    assign lk_hit_v[w] = vld_q[lk_set] && (tag_q[lk_set] == lk_tag);
    assign lk_st_v[w]  = st_q[lk_set];
    assign up_vld_v[w] = vld_q[up_set];
    assign up_hit_v[w] = vld_q[up_set] && (tag_q[up_set] == up_tag);
    assign up_st_v[w]  = st_q[up_set];
  end

  // ---- update path ----
  logic             up_hit, wr_go, lru_touch, same_region;
  logic [WAY_W-1:0] up_way, free_way, lru_way, tgt_way, lk_way, touch_way;
  logic [SET_W-1:0] touch_set;
  logic             has_free;
  rstate_e          up_old;
  rview_t           wr_view, tbl_view;

  always_comb begin
    up_hit   = |up_hit_v;
    up_way   = '0;
    up_old   = RS_CLEAN;
    has_free = 1'b0;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (up_hit_v[w]) begin
        up_way = WAY_W'(w);
        up_old = up_st_v[w];
      end
      if (!up_vld_v[w]) begin
        has_free = 1'b1;
        free_way = WAY_W'(w);
      end
    end
    wr_view = next_view(up_hit, up_old, up_kind);
    wr_go   = up_en && wr_view.valid;
    if (up_hit)        tgt_way = up_way;
    else if (has_free) tgt_way = free_way;
    else               tgt_way = lru_way;
    for (int w = 0; w < WAYS; w++)
      wr_en[w] = wr_go && (tgt_way == WAY_W'(w));
  end

  // ---- lookup path with update bypass ----
  always_comb begin
    tbl_view.valid = |lk_hit_v;
    tbl_view.st    = RS_CLEAN;
    lk_way         = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (lk_hit_v[w]) begin
        tbl_view.st = lk_st_v[w];
        lk_way      = WAY_W'(w);
      end
    end
    same_region = wr_go && (up_set == lk_set) && (up_tag == lk_tag);
    lk_view     = same_region ? wr_view : tbl_view;
  end

  // an update write owns the recency port; a request hit uses it otherwise
  always_comb begin
    lru_touch = 1'b0;
    touch_set = lk_set;
    touch_way = lk_way;
    if (wr_go) begin
      lru_touch = 1'b1;
      touch_set = up_set;
      touch_way = tgt_way;
    end else if (lk_en && tbl_view.valid) begin
      lru_touch = 1'b1;
    end
  end

  rhg_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
    .clk       (clk),
    .rst       (rst),
    .touch_en  (lru_touch),
    .touch_set (touch_set),
    .touch_way (touch_way),
    .vic_set   (up_set),
    .vic_way   (lru_way)
  );

  // R12
  lookup_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lk_hit_v));
  // R12
  update_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(up_hit_v));
  // R10
  skip_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (up_en && up_kind == UK_SKIP) |-> (wr_en == '0));

endmodule

// File: rtl/rhg_policy.sv
`timescale 1ns/1ps
module rhg_policy
  import rhg_pkg::*;
(
  input  logic [2:0] pol,
  input  logic       bcast,
  input  rview_t     view,
  output logic       spec
);

  logic is_dirty, was_dirty, any_clean;

  always_comb begin
    is_dirty  = view.valid && (view.st == RS_DIRTY);
    was_dirty = view.valid && (view.st == RS_WAS_DIRTY);
    any_clean = view.valid && (view.st == RS_CLEAN || view.st == RS_WAS_CLEAN);
    case (pol)
      POL_ALWAYS:       spec = 1'b1;
      POL_NEVER:        spec = 1'b0;
      POL_KNOWN_DIRTY:  spec = !is_dirty;
      POL_LIKELY_DIRTY: spec = !(is_dirty || was_dirty);
      POL_NOT_CLEAN:    spec = any_clean;
      POL_ALL_SNOOPS:   spec = !bcast;
      default:          spec = 1'b1;
    endcase
  end

endmodule

// File: rtl/region_hint_gen.sv
`timescale 1ns/1ps
module region_hint_gen
  import rhg_pkg::*;
#(
  parameter int ADDR_W       = 40,
  parameter int LINE_BYTES   = 64,
  parameter int REGION_BYTES = 512,
  parameter int SETS         = 256,
  parameter int WAYS         = 2,
  localparam int REG_SHIFT   = $clog2(REGION_BYTES),
  localparam int SET_W       = $clog2(SETS),
  localparam int TAG_W       = ADDR_W - REG_SHIFT - SET_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_bcast,
  input  logic [2:0]        policy_sel,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_addr,
  input  logic [1:0]        upd_kind,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_bcast,
  output logic              out_spec
);

  // R13
  initial begin : cfg_blk
    region_size_chk: assert ((REGION_BYTES & (REGION_BYTES - 1)) == 0
                             && REGION_BYTES >= 2 * LINE_BYTES
                             && REGION_BYTES <= 4096)
      else $error("region size out of range");
  end

  logic [SET_W-1:0] lk_set, up_set;
  logic [TAG_W-1:0] lk_tag, up_tag;
  logic             upd_ofs_unused;
  rview_t           lk_view;
  logic             spec_d;

  assign lk_set = req_addr[REG_SHIFT +: SET_W];
  assign lk_tag = req_addr[ADDR_W-1 -: TAG_W];
  assign up_set = upd_addr[REG_SHIFT +: SET_W];
  assign up_tag = upd_addr[ADDR_W-1 -: TAG_W];
  assign upd_ofs_unused = ^upd_addr[REG_SHIFT-1:0];

  rhg_table #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_table (
    .clk     (clk),
    .rst     (rst),
    .lk_en   (req_valid),
    .lk_set  (lk_set),
    .lk_tag  (lk_tag),
    .lk_view (lk_view),
    .up_en   (upd_valid),
    .up_set  (up_set),
    .up_tag  (up_tag),
    .up_kind (upd_kind_e'(upd_kind))
  );

  rhg_policy u_policy (
    .pol   (policy_sel),
    .bcast (req_bcast),
    .view  (lk_view),
    .spec  (spec_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_bcast <= 1'b0;
      out_spec  <= 1'b0;
    end else begin
      out_valid <= req_valid;
      if (req_valid) begin
        out_addr  <= req_addr;
        out_bcast <= req_bcast;
        out_spec  <= spec_d;
      end
    end
  end

  // R2
  out_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> out_valid);
  // R2
  no_req_no_out_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !out_valid);
  // R3
  always_spec_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && policy_sel == POL_ALWAYS) |=> out_spec);
  // R4
  never_spec_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && policy_sel == POL_NEVER) |=> !out_spec);
  // R8
  bcast_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && policy_sel == POL_ALL_SNOOPS) |=> (out_spec == !out_bcast));
  // R9
  reserved_pol_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && policy_sel > POL_ALL_SNOOPS) |=> out_spec);
  // R11
  bypass_dirty_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && upd_valid && upd_kind == UK_DIRTY
     && policy_sel == POL_KNOWN_DIRTY
     && req_addr[ADDR_W-1:REG_SHIFT] == upd_addr[ADDR_W-1:REG_SHIFT]) |=> !out_spec);

endmodule

// File: tb/region_hint_gen_test.sv
`timescale 1ns/1ps
module region_hint_gen_test;

  localparam int ADDR_W = 20;
  localparam int RB     = 512;
  localparam int NSETS  = 4;
  localparam int NWAYS  = 2;
  // bench-own state codes
  localparam int M_CL = 10, M_DI = 11, M_WC = 12, M_WD = 13;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              req_bcast = 1'b0;
  logic [2:0]        policy_sel = '0;
  logic              upd_valid = 1'b0;
  logic [ADDR_W-1:0] upd_addr = '0;
  logic [1:0]        upd_kind = '0;
  logic              out_valid, out_bcast, out_spec;
  logic [ADDR_W-1:0] out_addr;

  always #10 clk = ~clk;

  region_hint_gen #(.ADDR_W(ADDR_W), .LINE_BYTES(64), .REGION_BYTES(RB),
                    .SETS(NSETS), .WAYS(NWAYS)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_bcast(req_bcast), .policy_sel(policy_sel), .upd_valid(upd_valid),
    .upd_addr(upd_addr), .upd_kind(upd_kind), .out_valid(out_valid),
    .out_addr(out_addr), .out_bcast(out_bcast), .out_spec(out_spec));

  typedef struct {
    bit                v;
    logic [ADDR_W-1:0] a;
    bit                b;
    bit                s;
    string             req;
  } exp_t;

  exp_t sb[$];
  int   n_chk = 0, n_err = 0;
  bit   done = 0;

  // reference model: MRU-first region list per set, state per region
  int mru[NSETS][$];
  int mst[int];

  function automatic int setof(int r);
    return r % NSETS;
  endfunction

  function automatic void mtouch(int r);
    int s = setof(r);
    for (int i = 0; i < mru[s].size(); i++)
      if (mru[s][i] == r) begin
        mru[s].delete(i);
        break;
      end
    mru[s].push_front(r);
  endfunction

  function automatic bit mwrites(int r, int k);
    if (mst.exists(r)) return k != 3;
    return k == 1 || k == 2;
  endfunction

  function automatic void mupdate(int r, int k);
    int s = setof(r);
    int nv;
    if (!mwrites(r, k)) return;
    if (k == 2)      nv = M_DI;
    else if (k == 1) nv = M_CL;
    else if (mst[r] == M_DI) nv = M_WD;
    else if (mst[r] == M_CL) nv = M_WC;
    else nv = mst[r];
    if (mst.exists(r)) begin
      mst[r] = nv;
      mtouch(r);
    end else begin
      if (mru[s].size() == NWAYS) begin
        int old = mru[s].pop_back();
        mst.delete(old);
      end
      mru[s].push_front(r);
      mst[r] = nv;
    end
  endfunction

  function automatic bit espec(int pol, bit bc, int r);
    bit v = mst.exists(r);
    int st = v ? mst[r] : 0;
    case (pol)
      1: return 0;
      2: return !(v && st == M_DI);
      3: return !(v && (st == M_DI || st == M_WD));
      4: return v && (st == M_CL || st == M_WC);
      5: return !bc;
      default: return 1;
    endcase
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // driver: one cycle of stimulus, expected result pushed to the scoreboard
  task automatic step(bit rv, int rr, int off, bit bc, int pol,
                      bit uv, int ru, int kind, string tag);
    exp_t e;
    bit uw = 0;
    req_valid  = rv;
    req_addr   = ADDR_W'(rr * RB + off);
    req_bcast  = bc;
    policy_sel = 3'(pol);
    upd_valid  = uv;
    upd_addr   = ADDR_W'(ru * RB + (off ^ 37) % RB);
    upd_kind   = 2'(kind);
    if (uv) begin
      uw = mwrites(ru, kind);
      mupdate(ru, kind);
    end
    e.v = rv; e.a = req_addr; e.b = bc; e.s = 0; e.req = tag;
    if (rv) begin
      e.s = espec(pol, bc, rr);
      if (mst.exists(rr) && !(uw && setof(ru) == setof(rr))) mtouch(rr);
    end
    sb.push_back(e);
    @(negedge clk);
  endtask

  task automatic rq(int r, int pol, bit bc, string tag, int off = 5);
    step(1, r, off, bc, pol, 0, 0, 0, tag);
  endtask

  task automatic up(int r, int kind, string tag);
    step(0, 0, 0, 0, 0, 1, r, kind, tag);
  endtask

  // monitor: compare outputs in the middle of the high phase
  always @(posedge clk) begin
    #5;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      if (e.v) begin
        check(out_valid == 1'b1, "R2", "out_valid", int'(out_valid), 1);
        check(out_addr == e.a && out_bcast == e.b, "R2", "passthrough",
              int'(out_addr), int'(e.a));
        check(out_spec == e.s, e.req, "out_spec", int'(out_spec), int'(e.s));
      end else begin
        check(out_valid == 1'b0, "R2", "idle out_valid", int'(out_valid), 0);
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL R2 watchdog: actual 0 expected 1 completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int seed = 7;
    // R1: requests during reset produce nothing
    req_valid = 1'b1;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
    rst = 1'b0;
    req_valid = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);

    // unknown region under every policy
    rq(1, 0, 1, "R3");
    rq(1, 1, 1, "R4");
    rq(1, 2, 1, "R5");
    rq(1, 3, 1, "R6");
    rq(1, 4, 1, "R7");
    rq(1, 5, 1, "R8");
    rq(1, 6, 1, "R9");
    rq(1, 7, 0, "R9");

    // dirty, then demoted to was-dirty (R10)
    up(1, 2, "R10");
    rq(1, 2, 1, "R5");
    rq(1, 3, 1, "R6");
    rq(1, 4, 1, "R7");
    rq(1, 0, 1, "R3");
    rq(1, 1, 0, "R4");
    up(1, 0, "R10");
    rq(1, 2, 1, "R10");
    rq(1, 3, 1, "R6");
    rq(1, 4, 1, "R7");
    up(1, 0, "R10");
    rq(1, 3, 1, "R10");

    // clean region, granularity within and across regions
    up(5, 1, "R10");
    rq(5, 4, 1, "R13", 0);
    rq(5, 4, 1, "R13", RB - 1);
    rq(6, 4, 1, "R13", 0);
    rq(5, 2, 1, "R5");
    rq(5, 3, 1, "R6");
    up(5, 0, "R10");
    rq(5, 4, 1, "R7");
    rq(5, 3, 1, "R6");

    // ignored update kinds
    up(9, 3, "R10");
    rq(9, 4, 1, "R10");
    up(9, 0, "R10");
    rq(9, 4, 1, "R10");
    up(1, 3, "R10");
    rq(1, 3, 1, "R10");

    // same-cycle update and request to one region
    step(1, 2, 9, 1, 2, 1, 2, 2, "R11");
    step(1, 2, 9, 1, 4, 1, 2, 1, "R11");
    step(1, 2, 9, 1, 3, 1, 2, 0, "R11");

    // replacement in set 0: regions 0, 4, 8, 12
    up(0, 1, "R12");
    up(4, 1, "R12");
    rq(0, 4, 1, "R12");
    up(8, 1, "R12");
    rq(4, 4, 1, "R12");
    rq(0, 4, 1, "R12");
    rq(8, 4, 1, "R12");
    up(12, 2, "R12");
    rq(0, 4, 1, "R12");
    rq(12, 2, 1, "R12");
    rq(8, 4, 1, "R12");

    // broadcast-only policy on a dirty region
    rq(12, 5, 0, "R8");
    rq(12, 5, 1, "R8");

    // mixed traffic, requests and updates on alternate cycles
    for (int i = 0; i < 96; i++) begin
      seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
      if (i % 2 == 0) up((seed >> 8) % 12, (seed >> 4) % 4, "R10");
      else if (i % 7 == 3) step(0, 0, 0, 0, 0, 0, 0, 0, "R2");
      else rq((seed >> 8) % 12, (seed >> 3) % 8, (seed >> 13) & 1, "R12",
              (seed >> 16) % RB);
    end
    step(0, 0, 0, 0, 0, 0, 0, 0, "R2");
    repeat (2) @(negedge clk);
    check(sb.size() == 0, "R2", "pending results", sb.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule